// File: doc/BRIEF.md
# Multi-format serial receiver with in-band flow control

This block turns an asynchronous RX line into a stream of received characters. The frame format is set at run time: 5 to 8 data bits sent LSB first, an optional parity bit checked as even, odd, mark or space, and 1, 1.5 or 2 stop bits. Line timing comes from an oversampling enable, `os_tick`, at OSR ticks per bit. Each character appears as a single-cycle `out_valid` pulse on `out_data`. The parity and framing error flags, and the event match, arrive in that same cycle.

When software flow control is on, the receiver removes the pause and resume characters (0x13 and 0x11 by default) from the stream. They drive `tx_pause`, which a companion transmitter uses to stop and restart. An all-zero frame with a low stop bit is reported on `out_brk` instead of as data. The buffering behind the block and any host access sit outside it.

Top module: `uart_fmt_rx`

## Requirements
- R1: `dbits` selects the data length: 0, 1, 2 and 3 give 5, 6, 7 and 8 bits. Bits arrive LSB first and are placed from `out_data[0]` upward. Bits above the selected length read as zero.
- R2: `par_mode` selects parity: 0 none, 1 even, 2 odd, 3 mark (bit must be 1), 4 space (bit must be 0), 5 to 7 none. For even and odd, the parity bit is compared with the data bits only. A mismatch sets `out_perr` in the same cycle as `out_valid`.
- R3: If the first stop bit samples low and the frame is not a break, the character is still delivered, with `out_ferr` set in the same cycle as `out_valid`.
- R4: A falling edge is confirmed as a start bit OSR/2 ticks later. A low pulse that has ended by then is dropped: no output appears, and the receiver waits for the next edge.
- R5: A frame whose data, parity and first stop bit are all zero raises a one-cycle `out_brk` and no `out_valid`. Reception resumes only after the line has returned high. An all-zero byte with a high stop bit is ordinary data.
- R6: With `fc_en` high, an error-free character equal to 0x13 sets `tx_pause` and an error-free 0x11 clears it. Neither produces `out_valid`. A flow character with an error, and any character while `fc_en` is low, is forwarded as data. `tx_pause` reads 0 while `fc_en` is low.
- R7: With `evt_en` high, a forwarded character equal to `evt_chr` raises `out_evt` in the same cycle as its `out_valid`.
- R8: Frames are accepted with 1, 1.5 or 2 stop bits. The receiver re-arms at the middle of the first stop bit, so a start bit can follow any of these stop lengths directly.
- R9: With `os_tick` held high, the outputs for a frame appear 3 + OSR/2 + OSR*(data bits + parity bits + 1) clock edges after the start bit is driven. `out_valid` lasts exactly one cycle.
- R10: While `rst_n` is low, all outputs are zero and the pause state is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| os_tick | input | 1 | Oversample enable, OSR per bit time |
| rxd | input | 1 | Serial receive line, idle high |
| dbits | input | 2 | Data length select (5 + value) |
| par_mode | input | 3 | Parity mode select |
| fc_en | input | 1 | Software flow control enable |
| evt_en | input | 1 | Event character match enable |
| evt_chr | input | 8 | Event character |
| out_valid | output | 1 | One-cycle received character strobe |
| out_data | output | 8 | Received character |
| out_perr | output | 1 | Parity error, with out_valid |
| out_ferr | output | 1 | Framing error, with out_valid |
| out_brk | output | 1 | Break detected pulse |
| out_evt | output | 1 | Event character match, with out_valid |
| tx_pause | output | 1 | Pause request for the companion transmitter |

## Verification
The bench builds the block with OSR = 16 and the default flow characters 0x11 and 0x13, and holds `os_tick` high. Each bit is then exactly sixteen clocks long, so the model can predict the output cycle of every frame and compare all outputs on every clock. Sixteen ticks per bit also give an eight-tick mid-start window. A five-clock glitch falls clearly inside that window, and stop lengths of 24 and 32 clocks stand for 1.5 and 2 stop bits.

// File: rtl/uart_fmt_rx.sv
module uart_fmt_rx #(
  parameter int OSR = 16,
  parameter logic [7:0] XON_CHAR = 8'h11,
  parameter logic [7:0] XOFF_CHAR = 8'h13
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       os_tick,
  input  logic       rxd,
  input  logic [1:0] dbits,
  input  logic [2:0] par_mode,
  input  logic       fc_en,
  input  logic       evt_en,
  input  logic [7:0] evt_chr,
  output logic       out_valid,
  output logic [7:0] out_data,
  output logic       out_perr,
  output logic       out_ferr,
  output logic       out_brk,
  output logic       out_evt,
  output logic       tx_pause
);
  localparam int CW = $clog2(OSR);
  localparam logic [CW-1:0] MID  = CW'(OSR / 2 - 1);
  localparam logic [CW-1:0] LAST = CW'(OSR - 1);

  typedef enum logic [1:0] {IDLE, START, SHIFT, HOLD} st_t;
  st_t st;

  logic          s1, rxs, pbit, paused, pexp;
  logic [CW-1:0] cnt;
  logic [3:0]    idx;
  logic [7:0]    sh;

  wire       has_par  = (par_mode != 3'd0) && (par_mode <= 3'd4);
  wire [3:0] nd       = 4'd5 + {2'b00, dbits};
  wire [3:0] stop_idx = nd + {3'b000, has_par};
  wire       stop_now = os_tick && st == SHIFT && cnt == LAST && idx == stop_idx;

  always_comb begin
    case (par_mode)
      3'd1:    pexp = ^sh;
      3'd2:    pexp = ~^sh;
      3'd3:    pexp = 1'b1;
      3'd4:    pexp = 1'b0;
      default: pexp = pbit;
    endcase
  end

  wire perr    = pbit != pexp;
  wire ferr    = !rxs;
  wire is_brk  = sh == 8'h00 && !pbit && !rxs;
  wire clean   = !perr && !ferr;
  wire is_xon  = fc_en && clean && sh == XON_CHAR;
  wire is_xoff = fc_en && clean && sh == XOFF_CHAR;
  wire fwd     = stop_now && !is_brk && !is_xon && !is_xoff;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1  <= 1'b1;
      rxs <= 1'b1;
    end else begin
      s1  <= rxd;
      rxs <= s1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st   <= IDLE;
      cnt  <= '0;
      idx  <= '0;
      sh   <= '0;
      pbit <= 1'b0;
    end else if (os_tick) begin
      unique case (st)
        IDLE: if (!rxs) begin
          st   <= START;
          cnt  <= '0;
          sh   <= '0;
          pbit <= 1'b0;
        end
        START: if (cnt == MID) begin
          st  <= rxs ? IDLE : SHIFT;
          cnt <= '0;
          idx <= '0;
        end else cnt <= cnt + 1'b1;
        SHIFT: if (cnt == LAST) begin
          cnt <= '0;
          idx <= idx + 4'd1;
          if (idx < nd) sh[idx[2:0]] <= rxs;
          else if (idx == nd && has_par) pbit <= rxs;
          if (idx == stop_idx) st <= is_brk ? HOLD : IDLE;
        end else cnt <= cnt + 1'b1;
        HOLD: if (rxs) st <= IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_perr  <= 1'b0;
      out_ferr  <= 1'b0;
      out_brk   <= 1'b0;
      out_evt   <= 1'b0;
      paused    <= 1'b0;
    end else begin
      out_valid <= fwd;
      out_perr  <= fwd && perr;
      out_ferr  <= fwd && ferr;
      out_brk   <= stop_now && is_brk;
      out_evt   <= fwd && evt_en && sh == evt_chr;
      if (fwd) out_data <= sh;
      if (stop_now && is_xoff) paused <= 1'b1;
      else if (stop_now && is_xon) paused <= 1'b0;
    end
  end

  assign tx_pause = fc_en && paused;
endmodule

// File: rtl/uart_fmt_rx_chk.sv
module uart_fmt_rx_chk (
  input logic clk,
  input logic rst_n,
  input logic fc_en,
  input logic evt_en,
  input logic out_valid,
  input logic out_perr,
  input logic out_ferr,
  input logic out_brk,
  input logic out_evt,
  input logic tx_pause
);
  // R9
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);
  // R5
  brk_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_brk |-> !out_valid);
  // R2
  perr_with_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_perr |-> out_valid);
  // R3
  ferr_with_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_ferr |-> out_valid);
  // R7
  evt_with_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_evt |-> (out_valid && evt_en));
  // R6
  pause_consumed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(tx_pause) && $stable(fc_en)) |-> !out_valid);
endmodule

bind uart_fmt_rx uart_fmt_rx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .fc_en(fc_en), .evt_en(evt_en),
  .out_valid(out_valid), .out_perr(out_perr), .out_ferr(out_ferr),
  .out_brk(out_brk), .out_evt(out_evt), .tx_pause(tx_pause)
);

// File: tb/sim_uart_fmt_rx.sv
module sim_uart_fmt_rx;
  localparam int OSR = 16;

  logic       clk = 1'b0, rst_n = 1'b0, rxd = 1'b1;
  logic       fc_en = 1'b0, evt_en = 1'b0;
  logic [1:0] dbits = 2'd3;
  logic [2:0] par_mode = 3'd0;
  logic [7:0] evt_chr = 8'h00;
  logic       out_valid, out_perr, out_ferr, out_brk, out_evt, tx_pause;
  logic [7:0] out_data;

  always #4 clk = ~clk;

  uart_fmt_rx #(.OSR(OSR)) u0 (
    .clk(clk), .rst_n(rst_n), .os_tick(1'b1), .rxd(rxd), .dbits(dbits),
    .par_mode(par_mode), .fc_en(fc_en), .evt_en(evt_en), .evt_chr(evt_chr),
    .out_valid(out_valid), .out_data(out_data), .out_perr(out_perr),
    .out_ferr(out_ferr), .out_brk(out_brk), .out_evt(out_evt), .tx_pause(tx_pause)
  );

  typedef struct {
    int         due;
    int         kind;
    logic [7:0] d;
    logic       pe, fe, ev;
  } ev_t;

  ev_t   q[$];
  string tq[$];
  int    cyc = 0, checks = 0, fails = 0;
  logic  mpause = 1'b0;
  bit    run = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(string tg, logic [15:0] a, logic [15:0] x);
    checks++;
    if (a !== x) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tg, a, x);
    end
  endtask

  always @(negedge clk) begin : mon
    ev_t         e;
    string       tg;
    bit          hit;
    logic [15:0] a, x;
    if (run) begin
      hit = (q.size() > 0) && (q[0].due == cyc);
      tg  = "R9";
      x   = 16'h0000;
      if (hit) begin
        e  = q.pop_front();
        tg = tq.pop_front();
        if (e.kind == 2) mpause = 1'b1;
        else if (e.kind == 1) mpause = 1'b0;
        if (e.kind == 0) x = {2'b00, 1'b1, 1'b0, e.pe, e.fe, e.ev, 1'b0, e.d};
        if (e.kind == 3) x[12] = 1'b1;
      end
      x[8] = fc_en & mpause;
      a = {2'b00, out_valid, out_brk, out_perr, out_ferr, out_evt, tx_pause,
           out_valid ? out_data : 8'h00};
      chk(tg, a, x);
    end
  end

  task automatic cfg(logic [1:0] db, logic [2:0] pm, logic fc, logic ee, logic [7:0] ec);
    @(posedge clk);
    #1;
    dbits = db; par_mode = pm; fc_en = fc; evt_en = ee; evt_chr = ec;
    @(negedge clk);
  endtask

  task automatic send(logic [7:0] b, int stopc, bit badp, bit bads, string tg);
    int         n, nb, ones;
    logic [7:0] d;
    logic       p;
    bit         hp, cons;
    ev_t        e;
    n  = 5 + int'(dbits);
    d  = b & 8'((1 << n) - 1);
    hp = (par_mode >= 3'd1) && (par_mode <= 3'd4);
    ones = 0;
    for (int i = 0; i < 8; i++) ones += int'(d[i]);
    case (par_mode)
      3'd1:    p = 1'(ones % 2);
      3'd2:    p = !(ones % 2);
      3'd3:    p = 1'b1;
      default: p = 1'b0;
    endcase
    if (badp) p = ~p;
    nb    = n + (hp ? 1 : 0);
    e.due = cyc + 3 + OSR / 2 + OSR * (nb + 1);
    e.d   = d;
    e.pe  = hp && badp;
    e.fe  = bads;
    cons  = fc_en && !e.pe && !bads && (d == 8'h11 || d == 8'h13);
    if (d == 8'h00 && (!hp || !p) && bads) e.kind = 3;
    else if (cons) e.kind = (d == 8'h13) ? 2 : 1;
    else e.kind = 0;
    e.ev = (e.kind == 0) && evt_en && d == evt_chr;
    q.push_back(e);
    tq.push_back(tg);
    rxd = 1'b0;
    repeat (OSR) @(negedge clk);
    for (int i = 0; i < n; i++) begin
      rxd = d[i];
      repeat (OSR) @(negedge clk);
    end
    if (hp) begin
      rxd = p;
      repeat (OSR) @(negedge clk);
    end
    if (bads) begin
      rxd = 1'b0;
      repeat (OSR) @(negedge clk);
    end
    rxd = 1'b1;
    repeat (stopc) @(negedge clk);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    chk("R10", {2'b00, out_valid, out_brk, out_perr, out_ferr, out_evt, tx_pause, out_data}, 16'h0000);
    rst_n = 1'b1;
    @(negedge clk);
    run = 1'b1;
    repeat (10) @(negedge clk);

    send(8'hA5, 16, 0, 0, "R9");
    send(8'h3C, 16, 0, 0, "R1");
    cfg(2'd2, 3'd1, 0, 0, 8'h00);
    send(8'h55, 16, 0, 0, "R2");
    send(8'h55, 16, 1, 0, "R2");
    cfg(2'd1, 3'd2, 0, 0, 8'h00);
    send(8'h2B, 16, 0, 0, "R2");
    send(8'h2B, 16, 1, 0, "R2");
    cfg(2'd0, 3'd3, 0, 0, 8'h00);
    send(8'hFF, 16, 0, 0, "R1");
    send(8'h0E, 16, 1, 0, "R2");
    cfg(2'd0, 3'd4, 0, 0, 8'h00);
    send(8'h0A, 24, 0, 0, "R8");
    send(8'h15, 24, 0, 0, "R8");
    send(8'h03, 32, 0, 0, "R8");
    send(8'h1C, 16, 1, 0, "R2");
    cfg(2'd3, 3'd0, 0, 0, 8'h00);
    send(8'h5A, 16, 0, 1, "R3");
    repeat (20) @(negedge clk);
    rxd = 1'b0;
    repeat (5) @(negedge clk);
    rxd = 1'b1;
    repeat (30) @(negedge clk);
    send(8'h81, 16, 0, 0, "R4");
    send(8'h00, 40, 0, 1, "R5");
    send(8'h42, 16, 0, 0, "R5");
    send(8'h00, 16, 0, 0, "R5");
    cfg(2'd3, 3'd0, 1, 0, 8'h00);
    send(8'h13, 16, 0, 0, "R6");
    send(8'h41, 16, 0, 0, "R6");
    send(8'h11, 16, 0, 0, "R6");
    cfg(2'd3, 3'd1, 1, 0, 8'h00);
    send(8'h13, 16, 1, 0, "R6");
    send(8'h13, 16, 0, 0, "R6");
    cfg(2'd3, 3'd1, 0, 0, 8'h00);
    send(8'h13, 16, 0, 0, "R6");
    cfg(2'd3, 3'd0, 0, 1, 8'h7E);
    send(8'h7E, 16, 0, 0, "R7");
    send(8'h7D, 16, 0, 0, "R7");
    cfg(2'd3, 3'd0, 1, 1, 8'h11);
    send(8'h11, 16, 0, 0, "R7");
    repeat (OSR * 12) @(negedge clk);
    run = 1'b0;
    if (q.size() != 0) begin
      fails++;
      $display("FAIL R9 act=%0d pending exp=0", q.size());
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule